// File: doc/BRIEF.md
# MII Management Command Engine

This block turns a single 32-bit command word into one complete management transaction on a two-wire serial management bus (a clock line plus a bidirectional data line) toward an external Ethernet PHY. Software writes the word, which carries a 16-bit data field, a 5-bit PHY address, a 5-bit PHY register number and a read/write select. The engine then builds the serial frame, generates the management clock from the system clock with a parameterised divider, and shifts the frame out. While it runs, a busy flag in the same register reads back as set.

For a read, the engine releases the data line at the turnaround and samples sixteen bits from the PHY. It places them in the data field of the command register and sets a read-valid flag. Every finished transaction, read or write, raises a one-cycle done pulse for an interrupt controller. A separate table register holds one 5-bit PHY address per port, and a port-select input looks up the address of any port.

Top module: `mdio_cmd_engine`

## Requirements
- R1: In the command register, the data field is bits 15:0, the PHY address is bits 20:16, the register number is bits 25:21 and bit 26 is the operation (1 = read, 0 = write). An accepted command reads back in these same positions.
- R2: Bit 28 of the command register reads 1 from the cycle after a command is accepted until the transaction completes.
- R3: The serial frame is 32 ones, then start bits 0,1, then the opcode (1,0 for read; 0,1 for write), then the PHY address MSB first, then the register number MSB first, then a turnaround, then 16 data bits MSB first. On a write the turnaround is driven as 1,0.
- R4: The management clock rests low. Each of its phases lasts HALF_DIV system clocks, and the line is low for the first phase of each bit. The data line changes only after a falling management-clock edge. A transaction takes exactly 128*HALF_DIV system clocks from the accepting edge to completion.
- R5: On a read, the data line is released from the first turnaround bit onward. Sixteen bits are sampled on rising management-clock edges, MSB first, and placed in bits 15:0. Bit 27 is set at completion.
- R6: On a write, the data line is driven through the last data bit and released at completion. Bit 27 stays 0.
- R7: Completion gives a done pulse exactly one system clock wide, on the same edge where bit 28 clears.
- R8: A command write that arrives while bit 28 is set is ignored. This includes a write on the completing edge. Nothing is sent, and the fields do not change.
- R9: Bit 27 clears when a new command is accepted.
- R10: In the PHY-address table, port n occupies bits 5n+4 down to 5n. The port_phy output returns the entry for port_sel, and returns 0 for a port_sel beyond the last port. The table reads back zero-extended.
- R11: After reset, both registers read 0, the management clock is low, the data line is released and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Command register readback, with busy and read-valid flags |
| tbl_wr | input | 1 | Write strobe for the PHY-address table |
| tbl_wdata | input | 32 | Table word to write |
| tbl_rdata | output | 32 | Table readback |
| port_sel | input | SEL_W | Port whose PHY address is looked up |
| port_phy | output | 5 | PHY address of the selected port |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |
| done_pulse | output | 1 | One-cycle completion event |

## Verification
A new command write and a transaction's completion can land on the same system-clock edge. At that edge busy is still set, so the write must be dropped and must not start a second frame. The bench holds the write strobe high on exactly the completing edge, counted as 128*HALF_DIV edges after acceptance, with a command whose every field differs from the running one. It then checks that done pulses, busy reads 0, the fields still hold the original command, and the bus stays idle afterward. The same intrusion is also placed mid-frame, and the captured frame is compared bit by bit with one computed from the original fields.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   // command register field layout (software decodes these positions)
   localparam int DATA_LSB   = 0;
   localparam int PHY_LSB    = 16;
   localparam int REG_LSB    = 21;
   localparam int OP_BIT     = 26;
   localparam int RVALID_BIT = 27;
   localparam int BUSY_BIT   = 28;
   localparam int AW         = 5;
   localparam int DW         = 16;
   localparam int HDR_LEN    = 14;  // start + opcode + phy + register
   localparam int TAIL_LEN   = 18;  // turnaround + data

   typedef struct packed {
      logic          rd;
      logic [AW-1:0] reg_a;
      logic [AW-1:0] phy;
      logic [DW-1:0] data;
   } mgmt_cmd_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_o,
   output logic fall_o
);
   logic wrap;
   logic mdc_q;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("mdio_clkdiv: HALF_DIV must be at least 1");
      end
      if (HALF_DIV == 1) begin : g_direct
         assign wrap = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(HALF_DIV);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (!run || wrap)   cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
         end
         assign wrap = (cnt_q == CW'(HALF_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mdc_q <= 1'b0;
      else if (!run)  mdc_q <= 1'b0;
      else if (wrap)  mdc_q <= ~mdc_q;
   end

   assign mdc    = mdc_q;
   assign rise_o = run && wrap && !mdc_q;
   assign fall_o = run && wrap && mdc_q;

   a_r4_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_o && fall_o));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  mgmt_cmd_t cmd,
   input  logic      rise,
   input  logic      fall,
   input  logic      mdio_i,
   output logic      run,
   output logic      fin_now,
   output logic      mdio_o,
   output logic      mdio_oe,
   output logic [DW-1:0] cap
);
   localparam int FLEN   = PRE_LEN + HDR_LEN + TAIL_LEN;
   localparam int BW     = $clog2(FLEN + 1);
   localparam int TA_IDX = PRE_LEN + HDR_LEN;
   localparam int D_IDX  = TA_IDX + 2;

   generate
      if (PRE_LEN < 1) begin : g_bad_pre
         $error("mdio_frame_seq: PRE_LEN must be at least 1");
      end
   endgenerate

   logic [FLEN-1:0] sh_q;
   logic [BW-1:0]   bidx_q;
   logic            run_q;
   logic            rd_q;
   logic [DW-1:0]   cap_q;
   logic            last_bit;

   assign last_bit = (bidx_q == BW'(FLEN - 1));
   assign fin_now  = run_q && fall && last_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         rd_q   <= 1'b0;
         bidx_q <= '0;
         sh_q   <= '0;
         cap_q  <= '0;
      end else if (start && !run_q) begin
         run_q  <= 1'b1;
         rd_q   <= cmd.rd;
         bidx_q <= '0;
         sh_q   <= {{PRE_LEN{1'b1}}, 2'b01, (cmd.rd ? 2'b10 : 2'b01),
                    cmd.phy, cmd.reg_a, (cmd.rd ? 2'b00 : 2'b10), cmd.data};
      end else if (run_q) begin
         if (rise && rd_q && bidx_q >= BW'(D_IDX))
            cap_q <= {cap_q[DW-2:0], mdio_i};
         if (fall) begin
            if (last_bit) begin
               run_q <= 1'b0;
            end else begin
               bidx_q <= bidx_q + 1'b1;
               sh_q   <= {sh_q[FLEN-2:0], 1'b1};
            end
         end
      end
   end

   assign run     = run_q;
   assign mdio_o  = sh_q[FLEN-1];
   assign mdio_oe = run_q && (!rd_q || bidx_q < BW'(TA_IDX));
   assign cap     = cap_q;

   // R4: the data line only moves after a falling management-clock edge
   a_r4_mdio_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(run_q) && !$stable(mdio_o)) |-> $past(fall));

   // R5: a read never drives the line once the turnaround is reached
   a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && rd_q && bidx_q >= BW'(TA_IDX)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_phy_table.sv
module mdio_phy_table #(
   parameter int NPORTS = 3,
   localparam int SEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tbl_wr,
   input  logic [31:0]      tbl_wdata,
   input  logic [SEL_W-1:0] port_sel,
   output logic [31:0]      tbl_rdata,
   output logic [4:0]       port_phy
);
   localparam int TW = NPORTS * 5;

   generate
      if (NPORTS < 1 || NPORTS > 6) begin : g_bad_ports
         $error("mdio_phy_table: NPORTS must be 1 to 6");
      end
   endgenerate

   logic [TW-1:0] tbl_q;
   logic [4:0]    fld [NPORTS];
   logic          unused_hi;

   assign unused_hi = ^tbl_wdata[31:TW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tbl_q <= '0;
      else if (tbl_wr) tbl_q <= tbl_wdata[TW-1:0];
   end

   for (genvar n = 0; n < NPORTS; n++) begin : g_field
      assign fld[n] = tbl_q[5*n +: 5];
   end

   always_comb begin
      port_phy = '0;
      for (int n = 0; n < NPORTS; n++)
         if (port_sel == SEL_W'(n)) port_phy = fld[n];
   end

   always_comb begin
      tbl_rdata = '0;
      tbl_rdata[TW-1:0] = tbl_q;
   end

   // R10: table only changes on a write strobe
   a_r10_table_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tbl_wr |=> $stable(tbl_q));
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
   import mdio_pkg::*;
#(
   parameter int HALF_DIV = 4,
   parameter int PRE_LEN  = 32,
   parameter int NPORTS   = 3,
   localparam int SEL_W   = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [31:0]      cmd_wdata,
   output logic [31:0]      cmd_rdata,
   input  logic             tbl_wr,
   input  logic [31:0]      tbl_wdata,
   output logic [31:0]      tbl_rdata,
   input  logic [SEL_W-1:0] port_sel,
   output logic [4:0]       port_phy,
   output logic             mdc,
   output logic             mdio_o,
   output logic             mdio_oe,
   input  logic             mdio_i,
   output logic             done_pulse
);
   mgmt_cmd_t     wr_cmd;
   mgmt_cmd_t     cmd_q;
   logic          rvalid_q;
   logic          done_q;
   logic          busy;
   logic          accept;
   logic          fin_now;
   logic          rise;
   logic          fall;
   logic [DW-1:0] cap;
   logic          unused_top;

   assign unused_top = ^cmd_wdata[31:OP_BIT+1];

   assign wr_cmd = '{rd:    cmd_wdata[OP_BIT],
                     reg_a: cmd_wdata[REG_LSB +: AW],
                     phy:   cmd_wdata[PHY_LSB +: AW],
                     data:  cmd_wdata[DATA_LSB +: DW]};
   assign accept = cmd_wr && !busy;

   mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy),
      .mdc(mdc), .rise_o(rise), .fall_o(fall));

   mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(accept), .cmd(wr_cmd),
      .rise(rise), .fall(fall), .mdio_i(mdio_i),
      .run(busy), .fin_now(fin_now),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .cap(cap));

   mdio_phy_table #(.NPORTS(NPORTS)) u_tbl (
      .clk(clk), .rst_n(rst_n), .tbl_wr(tbl_wr), .tbl_wdata(tbl_wdata),
      .port_sel(port_sel), .tbl_rdata(tbl_rdata), .port_phy(port_phy));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         rvalid_q <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= fin_now;
         if (accept) begin
            cmd_q    <= wr_cmd;
            rvalid_q <= 1'b0;
         end else if (fin_now && cmd_q.rd) begin
            cmd_q.data <= cap;
            rvalid_q   <= 1'b1;
         end
      end
   end

   always_comb begin
      cmd_rdata = '0;
      cmd_rdata[DATA_LSB +: DW] = cmd_q.data;
      cmd_rdata[PHY_LSB +: AW]  = cmd_q.phy;
      cmd_rdata[REG_LSB +: AW]  = cmd_q.reg_a;
      cmd_rdata[OP_BIT]         = cmd_q.rd;
      cmd_rdata[RVALID_BIT]     = rvalid_q;
      cmd_rdata[BUSY_BIT]       = busy;
   end

   assign done_pulse = done_q;

   a_r8_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable({cmd_q.rd, cmd_q.reg_a, cmd_q.phy}));
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   a_r7_done_with_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_q);
   a_r9_rvalid_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !rvalid_q);
   a_r11_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdio_oe && !mdc));
endmodule

// File: tb/sim_mdio_cmd_engine.sv
module sim_mdio_cmd_engine;
   localparam int CLK_PERIOD = 10;
   localparam int HDIV = 2;
   localparam int LAT  = 128 * HDIV;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [31:0] cmd_wdata = '0;
   logic [31:0] cmd_rdata;
   logic        tbl_wr = 1'b0;
   logic [31:0] tbl_wdata = '0;
   logic [31:0] tbl_rdata;
   logic [1:0]  port_sel = '0;
   logic [4:0]  port_phy;
   logic        mdc, mdio_o, mdio_oe, done_pulse;
   logic        mdio_i = 1'b0;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   int pos_i = 0;
   int neg_i = 0;
   logic [63:0] seen = '0;
   logic [63:0] oe_seen = '0;
   logic [15:0] phy_rd = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_cmd_engine #(.HALF_DIV(HDIV), .PRE_LEN(32), .NPORTS(3)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
      .cmd_rdata(cmd_rdata), .tbl_wr(tbl_wr), .tbl_wdata(tbl_wdata),
      .tbl_rdata(tbl_rdata), .port_sel(port_sel), .port_phy(port_phy),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
      .done_pulse(done_pulse));

   // PHY side: record what is seen at each rising edge, answer reads on falling edges
   always @(posedge mdc) begin
      if (pos_i < 64) begin
         seen[63-pos_i]    = mdio_o;
         oe_seen[63-pos_i] = mdio_oe;
      end
      pos_i = pos_i + 1;
   end

   always @(negedge mdc) begin
      if (neg_i >= 47 && neg_i < 63) mdio_i = phy_rd[15-(neg_i-47)];
      neg_i = neg_i + 1;
   end

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_cmd(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                          input logic [15:0] data, input logic [15:0] resp,
                          input bit intr_mid, input bit intr_end);
      logic [31:0] w, alt;
      logic [63:0] expf, expoe, mask;
      bit early;
      w    = {5'b0, rd, ra, phy, data};
      alt  = {5'b0, ~rd, ~ra, ~phy, ~data};
      expf = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra,
              (rd ? 2'b00 : 2'b10), data};
      expoe = rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
      mask  = expoe;
      pos_i = 0; neg_i = 0; phy_rd = resp; mdio_i = 1'b0; early = 0;
      @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
      @(posedge clk);
      @(negedge clk); cmd_wr = 1'b0;
      check(cmd_rdata[28] == 1'b1, "R2 busy after accept", 64'(cmd_rdata[28]), 64'd1);
      check(cmd_rdata[27] == 1'b0, "R9 rvalid cleared on accept", 64'(cmd_rdata[27]), 64'd0);
      check(cmd_rdata[26:0] == w[26:0], "R1 fields read back", 64'(cmd_rdata[26:0]), 64'(w[26:0]));
      for (int n = 1; n <= LAT; n++) begin
         cmd_wr = (intr_mid && n == 40) || (intr_end && n == LAT);
         cmd_wdata = alt;
         @(posedge clk);
         @(negedge clk);
         if (n < LAT && (done_pulse || !cmd_rdata[28])) early = 1;
      end
      cmd_wr = 1'b0;
      check(!early, "R2 busy held and no early done", 64'(early), 64'd0);
      check(done_pulse == 1'b1, "R4 R7 done at 128*HALF_DIV", 64'(done_pulse), 64'd1);
      check(cmd_rdata[28] == 1'b0, "R7 busy clears with done", 64'(cmd_rdata[28]), 64'd0);
      check(pos_i == 64, "R4 rising edge count", 64'(pos_i), 64'd64);
      check((seen & mask) == (expf & mask), "R3 frame bits", seen & mask, expf & mask);
      check(oe_seen == expoe, rd ? "R5 read release" : "R6 write drive", oe_seen, expoe);
      check(cmd_rdata[26:16] == w[26:16], "R8 fields kept after intrusion",
            64'(cmd_rdata[26:16]), 64'(w[26:16]));
      if (rd) begin
         check(cmd_rdata[27] == 1'b1, "R5 rvalid set", 64'(cmd_rdata[27]), 64'd1);
         check(cmd_rdata[15:0] == resp, "R5 read data", 64'(cmd_rdata[15:0]), 64'(resp));
      end else begin
         check(cmd_rdata[27] == 1'b0, "R6 rvalid stays low", 64'(cmd_rdata[27]), 64'd0);
         check(cmd_rdata[15:0] == data, "R1 write data kept", 64'(cmd_rdata[15:0]), 64'(data));
      end
      @(posedge clk);
      @(negedge clk);
      check(done_pulse == 1'b0, "R7 done one cycle", 64'(done_pulse), 64'd0);
      check(cmd_rdata[28] == 1'b0 && !mdio_oe && !mdc, "R8 R6 bus idle after",
            {61'd0, cmd_rdata[28], mdio_oe, mdc}, 64'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(cmd_rdata == 32'd0, "R11 command reg reset", 64'(cmd_rdata), 64'd0);
      check(tbl_rdata == 32'd0, "R11 table reset", 64'(tbl_rdata), 64'd0);
      check(!mdc && !mdio_oe && !done_pulse, "R11 idle outputs",
            {61'd0, mdc, mdio_oe, done_pulse}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 table sweep
      for (int t = 0; t < 4; t++) begin
         logic [31:0] tv;
         tv = 32'hDEAD_BEEF * (t + 3) + 32'(t * 77);
         @(negedge clk); tbl_wr = 1'b1; tbl_wdata = tv;
         @(negedge clk); tbl_wr = 1'b0;
         check(tbl_rdata == {17'd0, tv[14:0]}, "R10 table readback",
               64'(tbl_rdata), 64'({17'd0, tv[14:0]}));
         for (int p = 0; p < 4; p++) begin
            logic [4:0] ex;
            ex = (p < 3) ? tv[5*p +: 5] : 5'd0;
            port_sel = 2'(p);
            #1;
            check(port_phy == ex, "R10 port lookup", 64'(port_phy), 64'(ex));
         end
      end

      run_cmd(1'b1, 5'h01, 5'h02, 16'h0000, 16'hA5C3, 1'b0, 1'b0);
      run_cmd(1'b0, 5'h1F, 5'h00, 16'h1234, 16'h0000, 1'b1, 1'b0);
      run_cmd(1'b1, 5'h00, 5'h1F, 16'hFFFF, 16'h0001, 1'b0, 1'b1);
      run_cmd(1'b0, 5'h15, 5'h0A, 16'hFFFF, 16'h0000, 1'b0, 1'b1);
      run_cmd(1'b1, 5'h0A, 5'h15, 16'h5555, 16'h8000, 1'b1, 1'b1);
      for (int i = 0; i < 8; i++) begin
         run_cmd(i[0], 5'(i * 4 + 1), 5'(31 - i * 3),
                 16'(16'h0F0F ^ (i * 4099)), 16'(16'h3C5A + i * 2731), 1'b0, i[1]);
      end

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule